// File: doc/BRIEF.md
# Serial-Programmed Clock Fan-Out Enable Controller

This block copies one reference clock onto thirteen non-inverting outputs and lets a host switch each output on or off over a two-wire serial bus. The serial side is a receive-only slave. It watches SCL and SDA, recognises START and STOP, matches a 7-bit device address, captures the data bytes that follow, and acknowledges each accepted byte by pulling SDA low. It never drives data back.

There is no register pointer. Every transfer fills control byte 0 first, then byte 1, and so on, so a host that wants to change byte 1 must also resend byte 0. Received bytes go into a shadow copy. The copy becomes the active enable set only when the transfer ends with STOP. Each output passes through a latch that is open while the reference clock is low. An enable change therefore only takes effect at the start of a high phase, and no output ever produces a shortened pulse.

Top module: `sclk_fanout_ctrl`

## Requirements
- R1: After synchronous reset (rst high for at least one clock) all 13 outputs are enabled and follow clk_ref.
- R2: An output whose enable bit is 0 is held low in both phases of clk_ref. An output whose enable bit is 1 equals clk_ref.
- R3: A first byte whose upper seven bits differ from parameter DEV_ADDR is not acknowledged, and everything until the next START is ignored: no acknowledge and no change to the outputs.
- R4: A first byte with DEV_ADDR and bit 0 = 1 (a read request) is not acknowledged, SDA is never pulled during that transfer, and the outputs do not change.
- R5: An address byte with DEV_ADDR and bit 0 = 0 is acknowledged. In the data bytes that follow, data byte 0 bits [7:0] enable outputs 7..0 and data byte 1 bits [4:0] enable outputs 12..8 (1 = on). Bits are sent MSB first.
- R6: A transfer that ends with STOP after only data byte 0 leaves outputs 12..8 at their previous setting.
- R7: Each data byte after a matching write address is acknowledged by pulling SDA low from the SCL falling edge after its eighth bit until the next SCL falling edge. Bytes beyond byte 1 are acknowledged and discarded.
- R8: The enables change only when STOP ends an addressed write that carried at least one data byte. A transfer interrupted by a repeated START leaves them unchanged.
- R9: SCL and SDA pass through two flip-flops into the clk_ref domain before edge, START and STOP detection. SDA is never pulled or released while SCL stays high, except in response to START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that is fanned out; also clocks all logic |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the wired bus line |
| sda_pull_o | output | 1 | 1 = pull the open-drain SDA line low (acknowledge) |
| clk_out | output | 13 | Gated copies of clk_ref, one per output |

## Verification
Writes use contrasting patterns: all zeros, the alternating values A5h and 15h, and all ones. A wrong bit order or a mis-mapped byte therefore shows up on specific outputs. A single-byte write separates ordered capture with retention of byte 1 from a design that clears bytes it did not receive. A four-byte write checks that the extra bytes are acknowledged and dropped. Wrong-address, read-request and restart-before-STOP transfers each carry enable-changing data, so a design that ignores the address, the direction bit or the STOP commit would alter the outputs. Every clock, the outputs are compared in the high phase against a behavioural model and required to be low in the low phase, which exposes runt or stuck pulses.

// File: rtl/sclk_fanout_pkg.sv
package sclk_fanout_pkg;

    localparam int FANOUT_W    = 13;
    localparam int SYNC_DEPTH  = 2;
    localparam int BYTE_W      = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK,
        RX_SKIP
    } rx_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic int ctrl_bytes(input int n_out);
        return (n_out + BYTE_W - 1) / BYTE_W;
    endfunction

    function automatic logic is_write_to(input logic [7:0] b, input logic [6:0] dev);
        return (b[7:1] == dev) && !b[0];
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync
    import sclk_fanout_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_q;
    logic              sda_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sr[s] <= 1'b1;
                    sda_sr[s] <= 1'b1;
                end else if (s == 0) begin
                    scl_sr[s] <= scl_i;
                    sda_sr[s] <= sda_i;
                end else begin
                    scl_sr[s] <= scl_sr[s-1];
                    sda_sr[s] <= sda_sr[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_sr[STAGES-1];
            sda_q <= sda_sr[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_sr[STAGES-1];
        ev.sda      = sda_sr[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_q;
        ev.scl_fall = ~ev.scl & scl_q;
        ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
    end

endmodule

// File: rtl/byte_rx.sv
module byte_rx
    import sclk_fanout_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NBYTES   = 2,
    localparam int        IDXW     = $clog2(NBYTES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_ev_t         ev,
    output logic            sda_pull_o,
    output logic            xfer_start_o,
    output logic            wr_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic [7:0]      wr_byte_o,
    output logic            commit_o
);
    localparam logic [IDXW-1:0] IDX_END = IDXW'(NBYTES);

    rx_state_e       state;
    logic [2:0]      bit_cnt;
    logic [7:0]      shreg;
    logic            have_byte;
    logic [IDXW-1:0] idx;
    logic            dirty;

    assign xfer_start_o = ev.start;
    assign commit_o     = ev.stop & dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            have_byte  <= 1'b0;
            idx        <= '0;
            dirty      <= 1'b0;
            sda_pull_o <= 1'b0;
            wr_o       <= 1'b0;
            wr_idx_o   <= '0;
            wr_byte_o  <= '0;
        end else begin
            wr_o <= 1'b0;
            if (ev.start) begin
                state      <= RX_ADDR;
                bit_cnt    <= '0;
                have_byte  <= 1'b0;
                idx        <= '0;
                dirty      <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (ev.stop) begin
                state      <= RX_IDLE;
                dirty      <= 1'b0;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    RX_ADDR, RX_DATA: begin
                        if (ev.scl_rise) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) have_byte <= 1'b1;
                        end else if (ev.scl_fall && have_byte) begin
                            have_byte <= 1'b0;
                            bit_cnt   <= '0;
                            if (state == RX_ADDR) begin
                                if (is_write_to(shreg, DEV_ADDR)) begin
                                    state      <= RX_ADDR_ACK;
                                    sda_pull_o <= 1'b1;
                                end else begin
                                    state <= RX_SKIP;
                                end
                            end else begin
                                state      <= RX_DATA_ACK;
                                sda_pull_o <= 1'b1;
                                dirty      <= 1'b1;
                                if (idx < IDX_END) begin
                                    wr_o      <= 1'b1;
                                    wr_idx_o  <= idx;
                                    wr_byte_o <= shreg;
                                    idx       <= idx + 1'b1;
                                end
                            end
                        end
                    end
                    RX_ADDR_ACK, RX_DATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            state      <= RX_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: acknowledge pull only begins right after an SCL falling edge
    a_r7_ack_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> $past(ev.scl_fall));

    // R9: SDA drive is steady while SCL stays high
    a_r9_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl) && !$past(ev.start) && !$past(ev.stop))
            |-> $stable(sda_pull_o));

    // R3, R4: an ignored transfer never pulls SDA
    a_r3_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (state == RX_SKIP) |-> !sda_pull_o);

endmodule

// File: rtl/enable_bank.sv
module enable_bank
    import sclk_fanout_pkg::*;
#(
    parameter int  NUM_OUT = FANOUT_W,
    parameter int  NBYTES  = ctrl_bytes(NUM_OUT),
    localparam int IDXW    = $clog2(NBYTES + 1),
    localparam int SH_W    = NBYTES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               wr_i,
    input  logic [IDXW-1:0]    wr_idx_i,
    input  logic [7:0]         wr_byte_i,
    input  logic               commit_i,
    output logic [NUM_OUT-1:0] en_o
);
    logic [SH_W-1:0]    shadow;
    logic [NUM_OUT-1:0] active;

    assign en_o = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '1;
        end else if (load_i) begin
            shadow <= SH_W'(active) | ~{{NUM_OUT{1'b0}}, {(SH_W-NUM_OUT){1'b1}}} << NUM_OUT;
        end else if (wr_i) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_idx_i == IDXW'(b)) shadow[b*BYTE_W +: BYTE_W] <= wr_byte_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '1;
        end else if (commit_i) begin
            active <= shadow[NUM_OUT-1:0];
        end
    end

    // R1: enables come out of reset all on
    a_r1_reset_all_on: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&active));

    // R8: enables change only on a committing STOP
    a_r8_change_at_stop: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> ($past(commit_i) || $past(rst)));

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
    parameter int NUM_OUT = 13
) (
    input  logic               clk,
    input  logic [NUM_OUT-1:0] en_i,
    output logic [NUM_OUT-1:0] clk_o
);
    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
            logic en_lat;
            always_latch begin
                if (!clk) en_lat = en_i[g];
            end
            assign clk_o[g] = clk & en_lat;
        end
    endgenerate
endmodule

// File: rtl/sclk_fanout_ctrl.sv
module sclk_fanout_ctrl
    import sclk_fanout_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_OUT  = FANOUT_W,
    localparam int        NBYTES   = ctrl_bytes(NUM_OUT),
    localparam int        IDXW     = $clog2(NBYTES + 1)
) (
    input  logic               clk_ref,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    output logic [NUM_OUT-1:0] clk_out
);
    bus_ev_t            ev;
    logic               xfer_start;
    logic               wr;
    logic [IDXW-1:0]    wr_idx;
    logic [7:0]         wr_byte;
    logic               commit;
    logic [NUM_OUT-1:0] en;

    bus_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk_ref),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    byte_rx #(.DEV_ADDR(DEV_ADDR), .NBYTES(NBYTES)) u_rx (
        .clk          (clk_ref),
        .rst          (rst),
        .ev           (ev),
        .sda_pull_o   (sda_pull_o),
        .xfer_start_o (xfer_start),
        .wr_o         (wr),
        .wr_idx_o     (wr_idx),
        .wr_byte_o    (wr_byte),
        .commit_o     (commit)
    );

    enable_bank #(.NUM_OUT(NUM_OUT), .NBYTES(NBYTES)) u_bank (
        .clk       (clk_ref),
        .rst       (rst),
        .load_i    (xfer_start),
        .wr_i      (wr),
        .wr_idx_i  (wr_idx),
        .wr_byte_i (wr_byte),
        .commit_i  (commit),
        .en_o      (en)
    );

    clk_gate_bank #(.NUM_OUT(NUM_OUT)) u_gate (
        .clk   (clk_ref),
        .en_i  (en),
        .clk_o (clk_out)
    );

endmodule

// File: tb/sclk_fanout_ctrl_tb_top.sv
module sclk_fanout_ctrl_tb_top;
    localparam logic [6:0] DEV = 7'h69;
    localparam int         Q   = 8;

    logic        clk_ref = 1'b0;
    logic        rst     = 1'b1;
    logic        scl_h   = 1'b1;
    logic        sda_h   = 1'b1;
    logic        sda_pull;
    logic [12:0] clk_out;
    wire         sda_line = sda_h & ~sda_pull;

    int          n_chk   = 0;
    int          n_fail  = 0;
    logic [12:0] exp_en  = 13'h1fff;
    int          settle  = 0;
    bit          mon_on  = 1'b0;
    bit          pull_seen = 1'b0;

    always #4 clk_ref = ~clk_ref;

    sclk_fanout_ctrl #(.DEV_ADDR(DEV)) dut_i (
        .clk_ref    (clk_ref),
        .rst        (rst),
        .scl_i      (scl_h),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .clk_out    (clk_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: high phase equals modelled enables, low phase all zero (R2, R5)
    initial begin
        forever begin
            @(posedge clk_ref); #1;
            if (sda_pull) pull_seen = 1'b1;
            if (mon_on) begin
                if (settle > 0) settle--;
                else chk(clk_out === exp_en, "R2 high phase vs model", 32'(clk_out), 32'(exp_en));
            end
            @(negedge clk_ref); #1;
            if (mon_on) chk(clk_out === 13'h0, "R2 low phase", 32'(clk_out), 0);
        end
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; waitq(Q);
        scl_h = 1'b1; waitq(Q);
        sda_h = 1'b0; waitq(Q);
        scl_h = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        settle = 60;
        sda_h = 1'b0; waitq(Q);
        scl_h = 1'b1; waitq(Q);
        sda_h = 1'b1; waitq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; waitq(Q);
            scl_h = 1'b1; waitq(Q);
            scl_h = 1'b0;
        end
        sda_h = 1'b1; waitq(Q);
        scl_h = 1'b1; waitq(Q / 2);
        acked = !sda_line;
        waitq(Q / 2);
        scl_h = 1'b0;
    endtask

    // Behavioural transfer with model update
    task automatic xfer(input logic [6:0] addr, input bit rd, input logic [7:0] data[$],
                        input bit do_stop, input string req);
        bit          ack;
        bit          hit;
        logic [12:0] pend;
        hit  = (addr == DEV) && !rd;
        pend = exp_en;
        bus_start();
        send_byte({addr, rd}, ack);
        chk(ack == hit, {req, " address ack"}, 32'(ack), 32'(hit));
        foreach (data[k]) begin
            send_byte(data[k], ack);
            chk(ack == hit, {req, " data ack"}, 32'(ack), 32'(hit));
            if (k == 0) pend[7:0]  = data[k];
            if (k == 1) pend[12:8] = data[k][4:0];
        end
        if (do_stop) begin
            bus_stop();
            if (hit && data.size() > 0) exp_en = pend;
        end
    endtask

    task automatic chk_out(input logic [12:0] e, input string req);
        repeat (20) @(posedge clk_ref);
        @(posedge clk_ref); #2;
        chk(clk_out === e, req, 32'(clk_out), 32'(e));
        @(negedge clk_ref); #2;
        chk(clk_out === 13'h0, req, 32'(clk_out), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk_ref);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] q[$];
        repeat (4) @(posedge clk_ref);
        @(negedge clk_ref); rst = 1'b0;
        repeat (4) @(posedge clk_ref);
        mon_on = 1'b1;
        chk_out(13'h1fff, "R1 reset all on");
        chk(sda_pull === 1'b0, "R1 no pull after reset", 32'(sda_pull), 0);

        q = '{8'h00, 8'h00};
        xfer(DEV, 1'b0, q, 1'b1, "R5");
        chk_out(13'h0000, "R2 all disabled");

        q = '{8'hA5, 8'h15};
        xfer(DEV, 1'b0, q, 1'b1, "R5");
        chk_out(13'h15A5, "R5 byte mapping");

        q = '{8'h3C};
        xfer(DEV, 1'b0, q, 1'b1, "R6");
        chk_out(13'h153C, "R6 byte1 kept");

        q = '{8'hFF, 8'h1F, 8'hAA, 8'h55};
        xfer(DEV, 1'b0, q, 1'b1, "R7");
        chk_out(13'h1FFF, "R7 extra bytes dropped");

        q = '{8'h00, 8'h00};
        xfer(7'h12, 1'b0, q, 1'b1, "R3");
        chk_out(13'h1FFF, "R3 wrong address ignored");

        pull_seen = 1'b0;
        q = '{8'h00, 8'h00};
        xfer(DEV, 1'b1, q, 1'b1, "R4");
        chk(pull_seen == 1'b0, "R4 read never pulled", 32'(pull_seen), 0);
        chk_out(13'h1FFF, "R4 read ignored");

        q = '{8'h12, 8'h0A};
        xfer(DEV, 1'b0, q, 1'b0, "R8");
        q = {};
        xfer(7'h12, 1'b0, q, 1'b1, "R8");
        chk_out(13'h1FFF, "R8 restart discards");

        q = '{8'h00, 8'h10};
        xfer(DEV, 1'b0, q, 1'b1, "R9");
        chk_out(13'h1000, "R9 synchronised write");

        summary();
    end

endmodule